// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire clocked serial link. A single shift register serves both directions: writing a byte into it starts a transfer, the bits leave on the serial data output one per clock period, and the bits arriving on the serial data input are shifted into the same register. After eight bits the register holds the received byte. Because no separate buffer exists, software must not write again until the transfer has finished.

The serial clock comes from one of two places. In internal mode a prescaler and an 8-bit rate value produce the clock, count out exactly eight periods and then park the clock high. In external mode a remote master supplies the clock. It is brought into the system clock domain through a two-flop synchroniser and acts on every edge, without stopping. Output data changes on a falling serial clock edge and input data is sampled on a rising edge. A one-cycle interrupt request marks the eighth rising edge. In internal mode the data output keeps driving its last bit for half a serial period after the transfer and then floats.

Top module: `sio_shift_port`

## Requirements
- R1: After reset `busy`, `irq` and `sdout_oe` are 0 and `sclk_out` is 1.
- R2: A pulse on `wr_en` loads `wr_data` and raises `busy`. `busy` stays high until the eighth rising serial clock edge. At that edge `busy` drops and `irq` is high for exactly one system cycle.
- R3: In internal mode each serial clock half period lasts (`rate`+1)*P system cycles, where P is 2 for `presc_sel`=00, 8 for 01 and 32 for 10 or 11. The eighth rising edge falls 16 half periods after the write.
- R4: With `msb_first`=0 bit 0 of the written byte is sent first and bit 7 last. With `msb_first`=1 the order is reversed. A new bit appears on `sdout` at each falling serial clock edge.
- R5: `sdin` is sampled at each rising serial clock edge. Once `busy` is low, `rx_data` holds the eight sampled bits with the first received bit in bit 0 (LSB first) or bit 7 (MSB first).
- R6: In internal mode `sclk_out` idles high and stops high after exactly eight periods.
- R7: In internal mode `sdout_oe` stays 1 for one half period after the eighth rising edge, then goes to 0.
- R8: A write while the output is driven clears `sdout_oe` in the next cycle. This includes a write during the post-transfer hold and a write in the same cycle the hold ends. The new transfer then starts normally.
- R9: In external mode every synchronised rising edge of `ext_sclk` shifts in one bit and every falling edge shifts out one bit. `irq` pulses on every eighth rising edge, and shifting continues past the eighth edge.
- R10: With `port_en`=0 both `sdout_oe` and `sclk_oe` are 0.
- R11: Whenever no data bit is being driven, `sdout` shows `idle_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the shift register |
| wr_data | input | DW | Byte to transmit |
| clk_src_int | input | 1 | 1: internal rate generator, 0: external clock |
| presc_sel | input | 2 | Prescaler select (00=/2, 01=/8, 1x=/32) |
| rate | input | RW | Rate value n |
| msb_first | input | 1 | Bit order select |
| idle_level | input | 1 | Data output level when not driving data |
| port_en | input | 1 | Enables the serial pin drivers |
| ext_sclk | input | 1 | External serial clock |
| sdin | input | 1 | Serial data input |
| sdout | output | 1 | Serial data output |
| sdout_oe | output | 1 | Output enable for sdout |
| sclk_out | output | 1 | Internal serial clock output |
| sclk_oe | output | 1 | Output enable for sclk_out |
| rx_data | output | DW | Shift register contents (received byte) |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete request pulse |

## Verification
The hazardous coincidence is a register write landing in the same system cycle as the expiry that ends the post-transfer output hold. Both events try to update the drive state and the rate counters. The bench asserts `wr_en` so that it is captured at exactly the edge where the hold would expire. It then requires `sdout_oe` low and `busy` high on the following cycle, and requires the new transfer to complete after exactly 16 half periods. A write issued midway through the hold is judged the same way.

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
  parameter int DW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          clk_src_int,
  input  logic [1:0]    presc_sel,
  input  logic [RW-1:0] rate,
  input  logic          msb_first,
  input  logic          idle_level,
  input  logic          port_en,
  input  logic          ext_sclk,
  input  logic          sdin,
  output logic          sdout,
  output logic          sdout_oe,
  output logic          sclk_out,
  output logic          sclk_oe,
  output logic [DW-1:0] rx_data,
  output logic          busy,
  output logic          irq
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] shreg;
  logic [CW-1:0] bit_cnt;
  logic [4:0]    pre_cnt, pre_max;
  logic [RW-1:0] rate_cnt;
  logic [2:0]    xs;
  logic sdo_q, drive_q, hold_q, busy_q, irq_q, sclk_q;
  logic run, tick, expire, fall_ev, rise_ev, done, out_bit;
  logic [DW-1:0] shifted;

  assign pre_max = (presc_sel == 2'b00) ? 5'd1 : (presc_sel == 2'b01) ? 5'd7 : 5'd31;
  assign run     = clk_src_int & (busy_q | hold_q);
  assign tick    = (pre_cnt == pre_max);
  assign expire  = run & tick & (rate_cnt == rate);

  assign fall_ev = clk_src_int ? (expire & busy_q & sclk_q)  : (~xs[1] & xs[2]);
  assign rise_ev = clk_src_int ? (expire & busy_q & ~sclk_q) : (xs[1] & ~xs[2]);
  assign done    = rise_ev & (bit_cnt == CW'(DW-1));

  assign out_bit = msb_first ? shreg[DW-1] : shreg[0];
  assign shifted = msb_first ? {shreg[DW-2:0], sdin} : {sdin, shreg[DW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xs <= 3'b111;
    else        xs <= {xs[1:0], ext_sclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (wr_en || !run) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (tick) begin
      pre_cnt  <= '0;
      rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      sdo_q   <= 1'b0;
      drive_q <= 1'b0;
      hold_q  <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      sclk_q  <= 1'b1;
    end else begin
      irq_q <= 1'b0;
      if (wr_en) begin
        shreg   <= wr_data;
        bit_cnt <= '0;
        busy_q  <= 1'b1;
        drive_q <= 1'b0;
        hold_q  <= 1'b0;
        sclk_q  <= 1'b1;
      end else begin
        if (fall_ev) begin
          sdo_q   <= out_bit;
          drive_q <= 1'b1;
          if (clk_src_int) sclk_q <= 1'b0;
        end
        if (rise_ev) begin
          shreg   <= shifted;
          bit_cnt <= done ? '0 : bit_cnt + 1'b1;
          if (clk_src_int) sclk_q <= 1'b1;
          if (done) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            if (clk_src_int) hold_q <= 1'b1;
          end
        end
        if (expire && hold_q) begin
          hold_q  <= 1'b0;
          drive_q <= 1'b0;
        end
      end
    end
  end

  assign sdout    = drive_q ? sdo_q : idle_level;
  assign sdout_oe = port_en & drive_q;
  assign sclk_out = clk_src_int ? sclk_q : 1'b1;
  assign sclk_oe  = port_en & clk_src_int;
  assign rx_data  = shreg;
  assign busy     = busy_q;
  assign irq      = irq_q;
endmodule

module sio_shift_port_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic clk_src_int,
  input logic port_en,
  input logic busy,
  input logic irq,
  input logic sclk_out,
  input logic sdout_oe,
  input logic sclk_oe
);
  p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  p_busy_end_irq_r2: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> irq);
  p_write_busy_r2: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> busy);
  p_sclk_parks_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src_int && !busy) |-> sclk_out);
  p_write_floats_r8: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !sdout_oe);
  p_pins_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!sdout_oe && !sclk_oe));
endmodule

bind sio_shift_port sio_shift_port_chk chk_i (.*);

// File: tb/sio_shift_port_tb_top.sv
module sio_shift_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic clk_src_int = 1'b1;
  logic [1:0] presc_sel = '0;
  logic [7:0] rate = '0;
  logic msb_first = 1'b0;
  logic idle_level = 1'b1;
  logic port_en = 1'b1;
  logic ext_sclk = 1'b1;
  logic sdin = 1'b0;
  logic sdout, sdout_oe, sclk_out, sclk_oe, busy, irq;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, cyc = 0, irq_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sio_shift_port dut_i (.*);

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
      report();
    end
  end

  task automatic report();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int half_len(logic [1:0] ps, logic [7:0] r);
    int p = (ps == 2'b00) ? 2 : (ps == 2'b01) ? 8 : 32;
    return (int'(r) + 1) * p;
  endfunction

  function automatic logic [7:0] order_bits(logic [7:0] b, bit msb);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = msb ? b[7-i] : b[i];
    return o;
  endfunction

  // internal-clock transfer; cut_at>0 issues a second write at that count
  task automatic run_int(logic [7:0] d, logic [7:0] rxp, bit msb, logic [1:0] ps,
                         logic [7:0] r, int cut_at);
    int h = half_len(ps, r);
    int irq_at = -1, nb = 0, nr = 0;
    logic prev_sclk = 1'b1;
    logic [7:0] seen = '0;
    logic [7:0] send = order_bits(rxp, msb);
    clk_src_int = 1'b1; presc_sel = ps; rate = r; msb_first = msb;
    wr_data = d; wr_en = 1'b1;
    for (int k = 1; k <= 17*h + 2; k++) begin
      @(negedge clk);
      if (k == 1) wr_en = 1'b0;
      if (prev_sclk && !sclk_out) begin sdin = send[nr]; nr++; end
      if (!prev_sclk && sclk_out) begin seen[nb] = sdout; nb++; end
      prev_sclk = sclk_out;
      if (irq && irq_at < 0) irq_at = k;
      if (k == 16*h) check(busy == 1'b1, "R2 busy before end", busy, 1);
      if (cut_at > 0 && k == cut_at) begin
        wr_data = ~d; wr_en = 1'b1;
      end else if (cut_at > 0 && k == cut_at + 1) begin
        wr_en = 1'b0;
        check(sdout_oe == 1'b0, "R8 write cuts hold", sdout_oe, 0);
        check(busy == 1'b1, "R8 new transfer busy", busy, 1);
        break;
      end
      if (cut_at == 0 && k == 17*h) check(sdout_oe == 1'b1, "R7 hold drive", sdout_oe, 1);
      if (cut_at == 0 && k == 17*h + 1) begin
        check(sdout_oe == 1'b0, "R7 float after hold", sdout_oe, 0);
        check(sdout == idle_level, "R11 idle level", sdout, idle_level);
      end
    end
    check(irq_at == 16*h + 1, "R3 write-to-irq cycles", irq_at, 16*h + 1);
    check(rx_data == rxp, "R5 received byte", rx_data, rxp);
    check(order_bits(seen, msb) == d && nb == 8, "R4 transmit order", seen, order_bits(d, msb));
    if (cut_at > 0) begin
      // second transfer started by the cut write must finish on time
      irq_at = -1;
      for (int k = cut_at + 2; k <= cut_at + 16*h + 3; k++) begin
        @(negedge clk);
        if (irq && irq_at < 0) irq_at = k - cut_at;
      end
      check(irq_at == 16*h + 1, "R8 resumed transfer timing", irq_at, 16*h + 1);
      repeat (h + 2) @(negedge clk);
    end
    check(busy == 1'b0 && sclk_out == 1'b1, "R6 clock parked high", sclk_out, 1);
  endtask

  task automatic ext_bit(bit in_bit, output logic out_bit);
    ext_sclk = 1'b0; sdin = in_bit;
    repeat (6) @(negedge clk);
    out_bit = sdout;
    ext_sclk = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_ext(logic [7:0] d, logic [7:0] rxa, logic [7:0] rxb, bit msb);
    logic [7:0] sa = order_bits(rxa, msb), sb = order_bits(rxb, msb);
    logic [7:0] ta, tb;
    int i0;
    clk_src_int = 1'b0; msb_first = msb;
    @(negedge clk); wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    i0 = irq_cnt;
    for (int i = 0; i < 8; i++) ext_bit(sa[i], ta[i]);
    check(irq_cnt == i0 + 1, "R9 irq after eight edges", irq_cnt - i0, 1);
    check(rx_data == rxa, "R9 ext received byte", rx_data, rxa);
    check(order_bits(ta, msb) == d, "R9 ext transmit order", order_bits(ta, msb), d);
    check(busy == 1'b0, "R2 ext busy cleared", busy, 0);
    for (int i = 0; i < 8; i++) ext_bit(sb[i], tb[i]);
    check(irq_cnt == i0 + 2, "R9 shifting continues", irq_cnt - i0, 2);
    check(rx_data == rxb && order_bits(tb, msb) == rxa, "R9 second byte", rx_data, rxb);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(busy == 0 && irq == 0 && sdout_oe == 0 && sclk_out == 1, "R1 reset state",
          {busy, irq, sdout_oe, sclk_out}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    run_int(8'hA5, 8'h3C, 1'b0, 2'b00, 8'd0, 0);
    run_int(8'h81, 8'hC3, 1'b1, 2'b01, 8'd1, 0);
    idle_level = 1'b0;
    run_int(8'h5E, 8'h17, 1'b0, 2'b10, 8'd0, 0);
    idle_level = 1'b1;
    for (int t = 0; t < 5; t++) begin
      logic [1:0] ps = 2'($urandom_range(0, 3));
      logic [7:0] r = 8'($urandom_range(0, 3));
      idle_level = 1'($urandom);
      run_int(8'($urandom), 8'($urandom), 1'($urandom), ps, r, 0);
    end
    // write in the middle of the hold window
    run_int(8'h96, 8'h69, 1'b0, 2'b01, 8'd1, 16*16 + 1 + 8);
    // write landing in the same cycle the hold expires
    run_int(8'h0F, 8'hF0, 1'b1, 2'b00, 8'd2, 17*6);
    run_ext(8'hB2, 8'h4D, 8'hE1, 1'b0);
    run_ext(8'h6C, 8'h93, 8'h28, 1'b1);
    port_en = 1'b0;
    @(negedge clk);
    check(sdout_oe == 0 && sclk_oe == 0, "R10 pins disabled", {sdout_oe, sclk_oe}, 0);
    port_en = 1'b1;
    clk_src_int = 1'b1;
    @(negedge clk);
    check(sclk_oe == 1'b1, "R10 clock pin enabled", sclk_oe, 1);
    report();
  end
endmodule